// File: doc/BRIEF.md
# Register-Mapped I2C EEPROM Byte Controller

This block lets a host move single bytes to and from a serial EEPROM on a two-wire I2C bus. The host sees a handful of byte-wide registers: a memory address split into low and high bytes, a data byte, a control byte and a status byte. Once the control byte is set, the host starts a transfer with one register write. Writing the data byte while the write-mode bit is set stores one byte into the EEPROM. Writing the low address byte while the write-mode bit is clear fetches one byte, which then appears in the data register.

The host polls the two low status bits. They read 11 when the controller is idle and 00 while the bus is busy. They read 01 while the closing STOP is being sent. The pattern 10 never appears. If the EEPROM fails to acknowledge, the controller raises the acknowledge-error flag and closes the bus. This happens, for example, while the part is still busy with an earlier internal write. The host then repeats the operation. The bus lines are open-drain: each output is a pull-low enable. Bit timing comes from a parameterised divider, with four phases per bit and DIV clocks per phase.

Transaction states: S_IDLE, S_START, S_DEVW (device address with write bit), S_AHI (high address byte), S_ALO (low address byte), S_WDATA, S_RSTART (repeated START), S_DEVR (device address with read bit), S_RDATA and S_STOP. Each step leaves its state when the byte sequencer reports it done. The transitions are:
- S_IDLE→S_START on a legal launch.
- S_START→S_DEVW.
- S_DEVW→S_AHI in two-byte mode, otherwise S_DEVW→S_ALO.
- S_AHI→S_ALO.
- S_ALO→S_WDATA for a write, or S_ALO→S_RSTART for a read.
- S_WDATA→S_STOP.
- S_RSTART→S_DEVR, then S_DEVR→S_RDATA, then S_RDATA→S_STOP.
- Any byte state that sends a byte (S_DEVW, S_AHI, S_ALO, S_WDATA, S_DEVR) goes to S_STOP on NACK.
- S_STOP→S_IDLE.

Top module: `eeprom_byte_ctrl`

## Requirements
- R1: Register offsets are 0xAC for the address low byte, 0xAD for the address high byte, 0xB0 for data, 0xB1 for control and 0xB2 for status. After reset, the address, data and control registers read 0x00 and status reads 0x03. Status bits 7:4 always read 0.
- R2: The control fields are: bit 7 enables the interface, bit 6 selects write (1), and bit 5 selects two-byte addressing. With bit 7 set and bits 3, 1 and 0 clear, writing 0xB0 while bit 6 is 1 performs one byte write. The byte write is START, 0xA0, the address byte(s), the data byte, then STOP.
- R3: Writing 0xAC while bit 6 is 0 performs one byte read. The byte read is START, 0xA0, the address byte(s), a repeated START, 0xA1, one received byte answered with NACK, then STOP. The received byte is then readable at 0xB0.
- R4: Status bits 1:0 read 11 when idle, 00 during the transfer and 01 during the final STOP. They never read 10.
- R5: With control bit 5 set, the high address byte is sent before the low byte. With bit 5 clear, only the low address byte is sent.
- R6: SDA changes only while SCL is low, except during START and STOP conditions. Each transfer has exactly one STOP. Both lines are released whenever status bit 1 is 1.
- R7: A NACK on any byte the controller sends sets status bit 2. The controller then sends STOP and returns to idle, and no data byte is delivered to the memory.
- R8: A launch attempted while bit 7 is clear, or while bit 3, 1 or 0 is set, sets status bit 3. It causes no bus activity and leaves status bits 1:0 at 11.
- R9: Writes to 0xAC, 0xAD, 0xB0 and 0xB1 are ignored while status bit 1 is 0.
- R10: Both error flags clear when the next legal operation starts.
- R11: Writing 0xB0 with bit 6 clear, writing 0xAC with bit 6 set, or writing 0xAD only stores the byte and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational on host_addr) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The checker watches four things on every cycle:
- the ready and idle bits never form 10;
- SDA never moves while SCL is high outside a START or STOP;
- the lines are released while idle;
- control and address do not change under a busy write, and the error flags read clear the cycle after a launch.

Only the bench's scenarios, run against an EEPROM model, can show the byte-level results. These are the correct memory contents and returned byte, the high address byte being sent first, the final NACK on a read, NACK abandonment, and the absence of bus traffic on an illegal launch.

// File: rtl/eebc_pkg.sv
package eebc_pkg;
    typedef enum logic [1:0] {BC_START, BC_STOP, BC_WR, BC_RD} bitcmd_e;
    typedef enum logic [1:0] {OP_START, OP_STOP, OP_TX, OP_RX} byteop_e;
    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEVW, S_AHI, S_ALO, S_WDATA,
        S_RSTART, S_DEVR, S_RDATA, S_STOP
    } xfer_e;

    localparam logic [7:0] REG_ALO  = 8'hAC;
    localparam logic [7:0] REG_AHI  = 8'hAD;
    localparam logic [7:0] REG_DATA = 8'hB0;
    localparam logic [7:0] REG_CTRL = 8'hB1;
    localparam logic [7:0] REG_STAT = 8'hB2;

    localparam int CB_SEQ    = 0;
    localparam int CB_PAGE   = 1;
    localparam int CB_RELOAD = 3;
    localparam int CB_TWO    = 5;
    localparam int CB_WR     = 6;
    localparam int CB_EN     = 7;
endpackage

// File: rtl/eebc_bit_engine.sv
module eebc_bit_engine
    import eebc_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  bitcmd_e cmd,
    input  logic    din,
    input  logic    sda_in,
    output logic    done,
    output logic    dout,
    output logic    cond_active,
    output logic    scl_oe,
    output logic    sda_oe
);
    localparam int CW = $clog2(DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    bitcmd_e     cmd_q;
    logic        busy, bit_q, scl_hold, sda_hold, scl_n, sda_n;
    logic [1:0]  ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; cmd_q <= BC_STOP; bit_q <= 1'b1; ph <= '0; cnt <= '0;
            done <= 1'b0; dout <= 1'b1; scl_hold <= 1'b0; sda_hold <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1; cmd_q <= cmd; bit_q <= din; ph <= '0; cnt <= '0;
                end
            end else if (cnt == LAST) begin
                cnt <= '0;
                ph  <= ph + 2'd1;
                if (ph == 2'd2 && cmd_q == BC_RD) dout <= sda_in;
                if (ph == 2'd3) begin
                    busy <= 1'b0; done <= 1'b1;
                    scl_hold <= scl_n; sda_hold <= sda_n;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Line levels per phase; 1 means pull low.
    always_comb begin
        unique case (cmd_q)
            BC_START: begin scl_n = (ph == 2'd3); sda_n = (ph >= 2'd2); end
            BC_STOP:  begin scl_n = (ph == 2'd0); sda_n = (ph <= 2'd1); end
            BC_WR:    begin scl_n = (ph == 2'd0) || (ph == 2'd3); sda_n = ~bit_q; end
            BC_RD:    begin scl_n = (ph == 2'd0) || (ph == 2'd3); sda_n = 1'b0; end
            default:  begin scl_n = 1'b0; sda_n = 1'b0; end
        endcase
    end

    assign scl_oe      = busy ? scl_n : scl_hold;
    assign sda_oe      = busy ? sda_n : sda_hold;
    assign cond_active = busy && (cmd_q == BC_START || cmd_q == BC_STOP);
endmodule

// File: rtl/eebc_byte_seq.sv
module eebc_byte_seq
    import eebc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  byteop_e  op,
    input  logic [7:0] tx_byte,
    input  logic     tx_ackbit,
    output logic     done,
    output logic     nack,
    output logic [7:0] rx_byte,
    output logic     b_go,
    output bitcmd_e  b_cmd,
    output logic     b_din,
    input  logic     b_done,
    input  logic     b_dout
);
    byteop_e    op_q;
    logic       busy, ackbit_q;
    logic [7:0] sh;
    logic [3:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; op_q <= OP_STOP; sh <= '0; cnt <= '0; ackbit_q <= 1'b1;
            done <= 1'b0; nack <= 1'b0; b_go <= 1'b0; b_cmd <= BC_STOP; b_din <= 1'b1;
        end else begin
            b_go <= 1'b0;
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1; op_q <= op; sh <= tx_byte; cnt <= '0;
                    ackbit_q <= tx_ackbit; b_go <= 1'b1; b_din <= tx_byte[7];
                    unique case (op)
                        OP_START: b_cmd <= BC_START;
                        OP_STOP:  b_cmd <= BC_STOP;
                        OP_TX:    b_cmd <= BC_WR;
                        OP_RX:    b_cmd <= BC_RD;
                        default:  b_cmd <= BC_STOP;
                    endcase
                end
            end else if (b_done) begin
                if (op_q == OP_START || op_q == OP_STOP || cnt == 4'd8) begin
                    busy <= 1'b0; done <= 1'b1;
                    if (op_q == OP_TX) nack <= b_dout;
                end else begin
                    cnt  <= cnt + 4'd1;
                    sh   <= {sh[6:0], (op_q == OP_RX) ? b_dout : 1'b0};
                    b_go <= 1'b1;
                    if (cnt == 4'd7) begin
                        b_cmd <= (op_q == OP_TX) ? BC_RD : BC_WR;
                        b_din <= ackbit_q;
                    end else begin
                        b_cmd <= (op_q == OP_TX) ? BC_WR : BC_RD;
                        b_din <= sh[6];
                    end
                end
            end
        end
    end

    assign rx_byte = sh;
endmodule

// File: rtl/eeprom_byte_ctrl.sv
module eeprom_byte_ctrl
    import eebc_pkg::*;
#(
    parameter int         DIV      = 4,
    parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    xfer_e      state, state_nx;
    logic [15:0] addr_q;
    logic [7:0] data_q, ctrl_q, tx_byte, status, seq_rx;
    logic       ack_err, gen_err, rdy_q, go_q, host_idle;
    logic       want_launch, ctrl_legal, ack_fail, tx_state;
    logic       seq_done, seq_nack, b_go, b_din, b_done, b_dout, b_cond;
    byteop_e    op;
    bitcmd_e    b_cmd;

    assign host_idle   = (state == S_IDLE);
    assign ctrl_legal  = ctrl_q[CB_EN] && !ctrl_q[CB_RELOAD] && !ctrl_q[CB_PAGE] && !ctrl_q[CB_SEQ];
    assign want_launch = host_we && host_idle &&
                         (((host_addr == REG_DATA) &&  ctrl_q[CB_WR]) ||
                          ((host_addr == REG_ALO)  && !ctrl_q[CB_WR]));
    assign tx_state    = (state == S_DEVW) || (state == S_AHI) || (state == S_ALO) ||
                         (state == S_WDATA) || (state == S_DEVR);
    assign ack_fail    = seq_done && seq_nack && tx_state;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (want_launch && ctrl_legal) state_nx = S_START;
            S_START:  if (seq_done) state_nx = S_DEVW;
            S_DEVW:   if (seq_done) state_nx = seq_nack ? S_STOP : (ctrl_q[CB_TWO] ? S_AHI : S_ALO);
            S_AHI:    if (seq_done) state_nx = seq_nack ? S_STOP : S_ALO;
            S_ALO:    if (seq_done) state_nx = seq_nack ? S_STOP : (ctrl_q[CB_WR] ? S_WDATA : S_RSTART);
            S_WDATA:  if (seq_done) state_nx = S_STOP;
            S_RSTART: if (seq_done) state_nx = S_DEVR;
            S_DEVR:   if (seq_done) state_nx = seq_nack ? S_STOP : S_RDATA;
            S_RDATA:  if (seq_done) state_nx = S_STOP;
            S_STOP:   if (seq_done) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; go_q <= 1'b0; rdy_q <= 1'b1;
            addr_q <= '0; data_q <= '0; ctrl_q <= '0; ack_err <= 1'b0; gen_err <= 1'b0;
        end else begin
            state <= state_nx;
            go_q  <= (state_nx != state) && (state_nx != S_IDLE);
            if (state_nx != state) rdy_q <= (state_nx == S_STOP) || (state_nx == S_IDLE);
            if (host_we && host_idle) begin
                unique case (host_addr)
                    REG_ALO:  addr_q[7:0]  <= host_wdata;
                    REG_AHI:  addr_q[15:8] <= host_wdata;
                    REG_DATA: data_q       <= host_wdata;
                    REG_CTRL: ctrl_q       <= host_wdata;
                    default:  ;
                endcase
            end
            if (want_launch) begin
                ack_err <= 1'b0;
                gen_err <= !ctrl_legal;
            end
            if (ack_fail) ack_err <= 1'b1;
            if (state == S_RDATA && seq_done) data_q <= seq_rx;
        end
    end

    // Outputs: byte operation per state and register read mux
    always_comb begin
        op      = OP_TX;
        tx_byte = 8'h00;
        unique case (state)
            S_START, S_RSTART: op = OP_START;
            S_STOP:            op = OP_STOP;
            S_RDATA:           op = OP_RX;
            S_DEVW:            tx_byte = {DEV_ADDR, 1'b0};
            S_DEVR:            tx_byte = {DEV_ADDR, 1'b1};
            S_AHI:             tx_byte = addr_q[15:8];
            S_ALO:             tx_byte = addr_q[7:0];
            S_WDATA:           tx_byte = data_q;
            default:           ;
        endcase
        status = {4'b0000, gen_err, ack_err, host_idle, rdy_q};
        unique case (host_addr)
            REG_ALO:  host_rdata = addr_q[7:0];
            REG_AHI:  host_rdata = addr_q[15:8];
            REG_DATA: host_rdata = data_q;
            REG_CTRL: host_rdata = ctrl_q;
            REG_STAT: host_rdata = status;
            default:  host_rdata = 8'h00;
        endcase
    end

    eebc_byte_seq seq_i (
        .clk(clk), .rst_n(rst_n), .go(go_q), .op(op), .tx_byte(tx_byte),
        .tx_ackbit(1'b1), .done(seq_done), .nack(seq_nack), .rx_byte(seq_rx),
        .b_go(b_go), .b_cmd(b_cmd), .b_din(b_din), .b_done(b_done), .b_dout(b_dout)
    );

    eebc_bit_engine #(.DIV(DIV)) bit_i (
        .clk(clk), .rst_n(rst_n), .go(b_go), .cmd(b_cmd), .din(b_din), .sda_in(sda_in),
        .done(b_done), .dout(b_dout), .cond_active(b_cond), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/eebc_checker.sv
module eebc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  status,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        cond_active,
    input logic        host_we,
    input logic [7:0]  host_addr,
    input logic [7:0]  ctrl_q,
    input logic [15:0] addr_q
);
    assert_no_illegal_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] != 2'b10);

    assert_sda_stable_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && !cond_active && !$past(cond_active)) |-> $stable(sda_oe));

    assert_bus_released_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> (!scl_oe && !sda_oe));

    assert_ctrl_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !status[1] && (host_addr == 8'hB1)) |=> $stable(ctrl_q));

    assert_addr_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !status[1] && (host_addr == 8'hAC || host_addr == 8'hAD)) |=> $stable(addr_q));

    assert_flags_clear_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[1]) |-> (status[3:2] == 2'b00));

    assert_upper_status_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:4] == 4'b0000);
endmodule

bind eeprom_byte_ctrl eebc_checker chk_i (
    .clk(clk), .rst_n(rst_n), .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cond_active(b_cond), .host_we(host_we), .host_addr(host_addr),
    .ctrl_q(ctrl_q), .addr_q(addr_q)
);

// File: tb/eeprom_byte_ctrl_tb_top.sv
module eeprom_byte_ctrl_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
    logic [7:0] host_addr = 8'h00, host_wdata = 8'h00, host_rdata;
    logic scl_oe, sda_oe, scl, sda, drv = 1'b0;
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    assign scl = scl_oe ? 1'b0 : 1'b1;
    assign sda = (sda_oe || drv) ? 1'b0 : 1'b1;

    always #5 clk = ~clk;

    eeprom_byte_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    // EEPROM model (device address 0x50)
    logic [7:0] mem [256];
    logic [7:0] sh = 8'h00, lo = 8'h00, hi_seen = 8'h00;
    logic scl_p = 1'b1, sda_p = 1'b1, ack_slot = 1'b0, mnack = 1'b0, got_hi = 1'b0;
    int phase = 9, bitn = 0, rcnt = 0, start_cnt = 0, stop_cnt = 0, wr_cnt = 0;
    bit nack_dev = 0, tb_two = 0;

    always @(scl, sda) begin
        if (scl_p === 1'b1 && scl === 1'b1 && sda_p === 1'b1 && sda === 1'b0) begin
            start_cnt++; phase = 0; bitn = 0; ack_slot = 1'b0; drv = 1'b0;
        end else if (scl_p === 1'b1 && scl === 1'b1 && sda_p === 1'b0 && sda === 1'b1) begin
            stop_cnt++; phase = 9; drv = 1'b0;
        end else if (scl_p === 1'b0 && scl === 1'b1) begin
            if (phase == 4 && !ack_slot) begin
                if (rcnt < 8) rcnt++;
                else if (rcnt == 8) begin mnack = sda; rcnt = 9; end
            end else if (!ack_slot && phase <= 3) begin
                sh = {sh[6:0], sda}; bitn++;
            end
        end else if (scl_p === 1'b1 && scl === 1'b0) begin
            if (phase == 9) drv = 1'b0;
            else if (ack_slot) begin
                ack_slot = 1'b0;
                if (phase == 4) begin rcnt = 0; drv = ~mem[lo][7]; end
                else drv = 1'b0;
            end else if (phase == 4) begin
                drv = (rcnt < 8) ? ~mem[lo][7-rcnt] : 1'b0;
            end else if (bitn == 8) begin
                bitn = 0;
                if (phase == 0) begin
                    if (sh[7:1] == 7'h50 && !nack_dev) begin
                        drv = 1'b1; ack_slot = 1'b1;
                        phase = sh[0] ? 4 : (tb_two ? 1 : 2);
                    end else begin drv = 1'b0; phase = 9; end
                end else begin
                    drv = 1'b1; ack_slot = 1'b1;
                    if (phase == 1) begin hi_seen = sh; got_hi = 1'b1; phase = 2; end
                    else if (phase == 2) begin lo = sh; phase = 3; end
                    else begin mem[lo] = sh; wr_cnt++; end
                end
            end
        end
        scl_p = scl; sda_p = sda;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    bit saw00, saw01, saw10;
    task automatic wait_done(output bit ok);
        logic [7:0] s;
        saw00 = 0; saw01 = 0; saw10 = 0; ok = 0;
        for (int i = 0; i < 5000; i++) begin
            rd(8'hB2, s);
            if (s[1:0] == 2'b00) saw00 = 1;
            if (s[1:0] == 2'b01) saw01 = 1;
            if (s[1:0] == 2'b10) saw10 = 1;
            if (s[1:0] == 2'b11) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(8'hB2, v); chk(v == 8'h03, "R1 status after reset", v, 8'h03);
        rd(8'hB1, v); chk(v == 8'h00, "R1 control after reset", v, 0);
        rd(8'hB0, v); chk(v == 8'h00, "R1 data after reset", v, 0);
        rd(8'hAC, v); chk(v == 8'h00, "R1 address after reset", v, 0);
        chk(!scl_oe && !sda_oe, "R6 lines released at reset", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_store_only;
        logic [7:0] v; int s0;
        s0 = start_cnt;
        wr(8'hB1, 8'h80); wr(8'hAD, 8'h12); wr(8'hB0, 8'h77);
        repeat (40) @(negedge clk);
        rd(8'hB0, v); chk(v == 8'h77, "R11 data stored", v, 8'h77);
        rd(8'hAD, v); chk(v == 8'h12, "R1 high address readback", v, 8'h12);
        rd(8'hB1, v); chk(v == 8'h80, "R1 control readback", v, 8'h80);
        chk(start_cnt == s0, "R11 no transfer on store", start_cnt - s0, 0);
        rd(8'hB2, v); chk(v == 8'h03, "R11 still idle", v, 8'h03);
    endtask

    task automatic t_write_1b;
        logic [7:0] v; int s0, p0; bit ok;
        tb_two = 0; got_hi = 0;
        wr(8'hB1, 8'hC0); wr(8'hAD, 8'h00);
        s0 = start_cnt; p0 = stop_cnt;
        wr(8'hAC, 8'h34);
        chk(start_cnt == s0, "R11 address write in write mode starts nothing", start_cnt - s0, 0);
        wr(8'hB0, 8'h9E);
        wait_done(ok);
        chk(ok, "R2 write completes", ok, 1);
        chk(mem[8'h34] == 8'h9E, "R2 memory written", mem[8'h34], 8'h9E);
        chk(start_cnt - s0 == 1 && stop_cnt - p0 == 1, "R6 one START one STOP",
            (start_cnt - s0) * 16 + (stop_cnt - p0), 17);
        chk(saw00 && saw01 && !saw10, "R4 handshake pattern", {saw10, saw01, saw00}, 3'b011);
        chk(!got_hi, "R5 one-byte address only", got_hi, 0);
        rd(8'hB2, v); chk(v == 8'h03, "R4 idle after write", v, 8'h03);
    endtask

    task automatic t_busy_ignored;
        logic [7:0] v; bit ok;
        wr(8'hB1, 8'hC0); wr(8'hAC, 8'h40);
        wr(8'hB0, 8'h11);
        repeat (10) @(negedge clk);
        wr(8'hB1, 8'h00); wr(8'hB0, 8'hEE); wr(8'hAC, 8'h99);
        wait_done(ok);
        chk(mem[8'h40] == 8'h11, "R9 memory gets launch value", mem[8'h40], 8'h11);
        rd(8'hB1, v); chk(v == 8'hC0, "R9 control held", v, 8'hC0);
        rd(8'hB0, v); chk(v == 8'h11, "R9 data held", v, 8'h11);
        rd(8'hAC, v); chk(v == 8'h40, "R9 address held", v, 8'h40);
    endtask

    task automatic t_read_1b;
        logic [7:0] v; int s0; bit ok;
        tb_two = 0; mnack = 0;
        wr(8'hB1, 8'h80);
        s0 = start_cnt;
        wr(8'hAC, 8'h34);
        wait_done(ok);
        rd(8'hB0, v); chk(v == 8'h9E, "R3 read byte", v, 8'h9E);
        chk(mnack == 1'b1, "R3 final NACK", mnack, 1);
        chk(start_cnt - s0 == 2, "R3 repeated START", start_cnt - s0, 2);
        chk(saw01 && !saw10, "R4 read handshake", {saw10, saw01}, 2'b01);
    endtask

    task automatic t_two_byte;
        logic [7:0] v; bit ok;
        tb_two = 1; got_hi = 0;
        wr(8'hB1, 8'hE0); wr(8'hAD, 8'h03); wr(8'hAC, 8'h21); wr(8'hB0, 8'h5C);
        wait_done(ok);
        chk(got_hi && hi_seen == 8'h03, "R5 high byte sent first", hi_seen, 8'h03);
        chk(mem[8'h21] == 8'h5C, "R5 two-byte write", mem[8'h21], 8'h5C);
        wr(8'hB1, 8'hA0); wr(8'hB0, 8'h00); wr(8'hAC, 8'h21);
        wait_done(ok);
        rd(8'hB0, v); chk(v == 8'h5C, "R5 two-byte read", v, 8'h5C);
        tb_two = 0;
    endtask

    task automatic t_nack;
        logic [7:0] v; int w0, p0; bit ok;
        nack_dev = 1; w0 = wr_cnt; p0 = stop_cnt;
        wr(8'hB1, 8'hC0); wr(8'hAC, 8'h50); wr(8'hB0, 8'h33);
        wait_done(ok);
        rd(8'hB2, v); chk(v == 8'h07, "R7 ack error flagged", v, 8'h07);
        chk(wr_cnt == w0, "R7 no data delivered", wr_cnt - w0, 0);
        chk(stop_cnt - p0 == 1, "R7 STOP sent", stop_cnt - p0, 1);
        nack_dev = 0;
    endtask

    task automatic t_illegal;
        logic [7:0] v; int s0;
        s0 = start_cnt;
        wr(8'hB1, 8'h40); wr(8'hB0, 8'h44);
        repeat (30) @(negedge clk);
        rd(8'hB2, v); chk(v == 8'h0B, "R8 disabled launch", v, 8'h0B);
        wr(8'hB1, 8'h81); wr(8'hAC, 8'h10);
        repeat (30) @(negedge clk);
        rd(8'hB2, v); chk(v == 8'h0B, "R8 sequential bit launch", v, 8'h0B);
        wr(8'hB1, 8'h88); wr(8'hAC, 8'h10);
        repeat (30) @(negedge clk);
        rd(8'hB2, v); chk(v == 8'h0B, "R8 reload bit launch", v, 8'h0B);
        chk(start_cnt == s0, "R8 no bus activity", start_cnt - s0, 0);
    endtask

    task automatic t_clear;
        logic [7:0] v; bit ok;
        wr(8'hB1, 8'hC0); wr(8'hAC, 8'h60);
        wr(8'hB0, 8'hA5);
        rd(8'hB2, v); chk(v[3:2] == 2'b00, "R10 flags clear at launch", v[3:2], 0);
        wait_done(ok);
        rd(8'hB2, v); chk(v == 8'h03, "R10 status clean after", v, 8'h03);
        chk(mem[8'h60] == 8'hA5, "R10 retry succeeds", mem[8'h60], 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_only();
        t_write_1b();
        t_busy_ignored();
        t_read_1b();
        t_two_byte();
        t_nack();
        t_illegal();
        t_clear();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule